// File: doc/BRIEF.md
# Shared Configuration SPI Pin Arbiter

This block owns the four pins of a configuration SPI bus (clock, serial-in, serial-out and the master chip select) and hands them either to a master-side bitstream loader or to a slave-side programming port. The slave side is selected by an external active-low select pin; the master side asks for the bus with a request and reports the end of loading with a done strobe. Two of the data pins change direction with the owner: while the slave owns the bus, serial-in is read and serial-out is driven; while the master owns it, serial-in is driven with master data and serial-out is sampled back to the loader.

The arbiter is a four-state machine. `OWN_IDLE` drives nothing. `OWN_SLAVE` hands the pins to the programming port. `OWN_MASTER` drives clock, data and chip select for the loader. `OWN_ABORT` is a single tri-stated cycle that marks a master transfer cut short by the slave select. Transitions: IDLE to SLAVE when the select is low; IDLE to MASTER on a request while the select is high; SLAVE to IDLE when the select rises; MASTER to IDLE on done, on a dropped request or on a disabled master port; MASTER to ABORT when the select falls; ABORT to SLAVE when the select is still low, otherwise to IDLE. The slave select also overrides the master drivers combinationally, within the same cycle.

The master clock is produced inside the block from a divider that comes out of reset at a default setting and may be reprogrammed by the loader while the device is configuring. In user mode, a port whose enable bit is clear loses all claim on its pins, which are flagged free for general-purpose use.

Top module: `spi_pin_arbiter`

## Requirements
- R1: After reset the machine is idle: every pin output enable is 0, the chip-select value is 1, the grant, select and abort outputs are 0, and `div_cur` equals `DIV_DEFAULT`.
- R2: Whenever `sn_i` is 0 and the slave port is allowed (configuring, or `slv_en`=1), `cs_oe`, `sck_oe`, `si_oe` and `mst_grant` are 0 in that same cycle, without waiting for a clock edge.
- R3: One clock edge after the select is seen low from idle (or from the abort cycle), the slave owns the bus: `slv_sel`=1, `so_oe`=1 with `so_o`=`slv_miso`, and `slv_sck`/`slv_mosi` follow `sck_i`/`si_i`; these slave outputs read 0 otherwise. The slave wins when the select and a master request arrive together.
- R4: A master request with the select high and the master allowed is granted one edge later: `mst_grant`=1, `cs_oe`=1 with `cs_o`=0, `si_oe`=1 with `si_o`=`mst_mosi`, `sck_oe`=1, and `mst_miso` follows `so_i` (0 when not granted).
- R5: The master clock reads 0 on the first granted cycle, is held 0 whenever not driven, and toggles after every `div_cur`+1 granted cycles (period 2·(`div_cur`+1)).
- R6: Done high, request low, or the master disallowed at an edge ends master ownership at that edge: clock, data and chip-select enables drop to 0.
- R7: A select falling during master ownership moves to the abort cycle: `mst_abort`=1 for exactly one cycle with all enables 0, followed by slave ownership if the select is still low.
- R8: Ownership never passes directly between ports: the cycle before the slave starts driving has no master enable set, and vice versa.
- R9: `div_load` with `user_mode`=0 loads `div_prog` into `div_cur` at that edge; in user mode it is ignored; a falling `user_mode` restores `DIV_DEFAULT`.
- R10: In user mode, `slv_en`=0 makes the select ignored and raises `rel_sn`; `mst_en`=0 blocks grants at once and raises `rel_cs`; both clear raises `rel_shared`. All release flags are 0 while configuring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| user_mode | input | 1 | 1 = user mode, 0 = configuring |
| slv_en | input | 1 | Slave port kept in user mode |
| mst_en | input | 1 | Master port kept in user mode |
| sn_i | input | 1 | Slave select pin, active low |
| mst_req | input | 1 | Master loader requests the bus |
| mst_done | input | 1 | Master loader received its last byte |
| mst_mosi | input | 1 | Master data to send on serial-in pin |
| mst_miso | output | 1 | Serial-out pin sampled for the master |
| mst_grant | output | 1 | Master currently drives the bus |
| mst_abort | output | 1 | Master transfer cut short (one cycle) |
| div_load | input | 1 | Load programmed clock divider |
| div_prog | input | DIV_W | Programmed divider value |
| div_cur | output | DIV_W | Divider in force |
| slv_miso | input | 1 | Slave data for serial-out pin |
| slv_sel | output | 1 | Slave port owns the bus |
| slv_sck | output | 1 | Clock pin seen by the slave |
| slv_mosi | output | 1 | Serial-in pin seen by the slave |
| sck_i | input | 1 | Clock pin input |
| sck_o | output | 1 | Clock pin output value |
| sck_oe | output | 1 | Clock pin output enable |
| si_i | input | 1 | Serial-in pin input |
| si_o | output | 1 | Serial-in pin output value |
| si_oe | output | 1 | Serial-in pin output enable |
| so_i | input | 1 | Serial-out pin input |
| so_o | output | 1 | Serial-out pin output value |
| so_oe | output | 1 | Serial-out pin output enable |
| cs_o | output | 1 | Master chip-select output value |
| cs_oe | output | 1 | Master chip-select output enable |
| rel_shared | output | 1 | Clock and data pins free for general use |
| rel_sn | output | 1 | Slave select pin free for general use |
| rel_cs | output | 1 | Master chip-select pin free for general use |

## Verification
A wrong ownership state shows on the pin enables at the first falling clock after the offending edge, since every enable is a direct decode of the state and the live select; the reference model compares all outputs every cycle, so a misrouted or stuck owner is reported within one cycle. A wrong divider count appears as a clock toggle one or more cycles early or late during a granted run, and a lost or doubled abort state shows as a missing or two-cycle abort pulse before the slave takes over.

// File: rtl/spi_arb_pkg.sv
`timescale 1ns/1ps
package spi_arb_pkg;

    typedef enum logic [1:0] {
        OWN_IDLE   = 2'd0,
        OWN_SLAVE  = 2'd1,
        OWN_MASTER = 2'd2,
        OWN_ABORT  = 2'd3
    } own_state_e;

endpackage

// File: rtl/spi_arb_fsm.sv
`timescale 1ns/1ps
module spi_arb_fsm
    import spi_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slv_active,
    input  logic       mst_want,
    output own_state_e own_st,
    output logic       is_slave,
    output logic       is_master,
    output logic       abort
);

    own_state_e st_q;
    own_state_e st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= OWN_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OWN_IDLE: begin
                if (slv_active) begin
                    st_d = OWN_SLAVE;
                end else if (mst_want) begin
                    st_d = OWN_MASTER;
                end
            end
            OWN_SLAVE: begin
                if (!slv_active) begin
                    st_d = OWN_IDLE;
                end
            end
            OWN_MASTER: begin
                if (slv_active) begin
                    st_d = OWN_ABORT;
                end else if (!mst_want) begin
                    st_d = OWN_IDLE;
                end
            end
            OWN_ABORT: begin
                st_d = slv_active ? OWN_SLAVE : OWN_IDLE;
            end
            default: st_d = OWN_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        is_slave  = 1'b0;
        is_master = 1'b0;
        abort     = 1'b0;
        unique case (st_q)
            OWN_IDLE:   ;
            OWN_SLAVE:  is_slave  = 1'b1;
            OWN_MASTER: is_master = 1'b1;
            OWN_ABORT:  abort     = 1'b1;
            default:    ;
        endcase
    end

    assign own_st = st_q;

endmodule

// File: rtl/spi_arb_clkgen.sv
`timescale 1ns/1ps
module spi_arb_clkgen #(
    parameter int DIV_W       = 8,
    parameter int DIV_DEFAULT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             user_mode,
    input  logic             div_load,
    input  logic [DIV_W-1:0] div_prog,
    output logic             mclk,
    output logic [DIV_W-1:0] div_cur
);

    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(DIV_DEFAULT);

    logic [DIV_W-1:0] cnt_q;
    logic             mclk_q;
    logic [DIV_W-1:0] div_q;
    logic             um_q;

    // half-period counter, parked low while not running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mclk_q <= 1'b0;
        end else if (!run) begin
            cnt_q  <= '0;
            mclk_q <= 1'b0;
        end else if (cnt_q >= div_q) begin
            cnt_q  <= '0;
            mclk_q <= ~mclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // divider select: default, then programmed value while configuring
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_RST;
            um_q  <= 1'b0;
        end else begin
            um_q <= user_mode;
            if (um_q && !user_mode) begin
                div_q <= DIV_RST;
            end else if (div_load && !user_mode) begin
                div_q <= div_prog;
            end
        end
    end

    assign mclk    = mclk_q;
    assign div_cur = div_q;

endmodule

// File: rtl/spi_arb_pinmux.sv
`timescale 1ns/1ps
module spi_arb_pinmux (
    input  logic user_mode,
    input  logic slv_en,
    input  logic mst_en,
    input  logic slave_on,
    input  logic grant,
    input  logic mclk,
    input  logic mst_mosi,
    input  logic slv_miso,
    input  logic sck_i,
    input  logic si_i,
    input  logic so_i,
    output logic sck_o,
    output logic sck_oe,
    output logic si_o,
    output logic si_oe,
    output logic so_o,
    output logic so_oe,
    output logic cs_o,
    output logic cs_oe,
    output logic mst_miso,
    output logic slv_sck,
    output logic slv_mosi,
    output logic rel_shared,
    output logic rel_sn,
    output logic rel_cs
);

    always_comb begin
        // master-driven pins
        sck_oe   = grant;
        sck_o    = grant & mclk;
        si_oe    = grant;
        si_o     = grant & mst_mosi;
        cs_oe    = grant;
        cs_o     = ~grant;
        mst_miso = grant & so_i;
        // slave-driven pins
        so_oe    = slave_on;
        so_o     = slave_on & slv_miso;
        slv_sck  = slave_on & sck_i;
        slv_mosi = slave_on & si_i;
        // release to general-purpose use
        rel_sn     = user_mode & ~slv_en;
        rel_cs     = user_mode & ~mst_en;
        rel_shared = user_mode & ~slv_en & ~mst_en;
    end

endmodule

// File: rtl/spi_pin_arbiter.sv
`timescale 1ns/1ps
module spi_pin_arbiter
    import spi_arb_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int DIV_DEFAULT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             user_mode,
    input  logic             slv_en,
    input  logic             mst_en,
    input  logic             sn_i,
    input  logic             mst_req,
    input  logic             mst_done,
    input  logic             mst_mosi,
    output logic             mst_miso,
    output logic             mst_grant,
    output logic             mst_abort,
    input  logic             div_load,
    input  logic [DIV_W-1:0] div_prog,
    output logic [DIV_W-1:0] div_cur,
    input  logic             slv_miso,
    output logic             slv_sel,
    output logic             slv_sck,
    output logic             slv_mosi,
    input  logic             sck_i,
    output logic             sck_o,
    output logic             sck_oe,
    input  logic             si_i,
    output logic             si_o,
    output logic             si_oe,
    input  logic             so_i,
    output logic             so_o,
    output logic             so_oe,
    output logic             cs_o,
    output logic             cs_oe,
    output logic             rel_shared,
    output logic             rel_sn,
    output logic             rel_cs
);

    logic       slv_allow;
    logic       mst_allow;
    logic       slv_active;
    logic       mst_want;
    logic       is_slave;
    logic       is_master;
    logic       grant;
    logic       slave_on;
    logic       mclk;
    own_state_e own_st;

    assign slv_allow  = ~user_mode | slv_en;
    assign mst_allow  = ~user_mode | mst_en;
    assign slv_active = ~sn_i & slv_allow;
    assign mst_want   = mst_req & mst_allow & ~mst_done;

    spi_arb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slv_active (slv_active),
        .mst_want   (mst_want),
        .own_st     (own_st),
        .is_slave   (is_slave),
        .is_master  (is_master),
        .abort      (mst_abort)
    );

    // the live select overrides the master drivers in the same cycle
    assign grant    = is_master & ~slv_active & mst_allow;
    assign slave_on = is_slave & slv_allow;

    spi_arb_clkgen #(
        .DIV_W       (DIV_W),
        .DIV_DEFAULT (DIV_DEFAULT)
    ) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (grant),
        .user_mode (user_mode),
        .div_load  (div_load),
        .div_prog  (div_prog),
        .mclk      (mclk),
        .div_cur   (div_cur)
    );

    spi_arb_pinmux u_pinmux (
        .user_mode  (user_mode),
        .slv_en     (slv_en),
        .mst_en     (mst_en),
        .slave_on   (slave_on),
        .grant      (grant),
        .mclk       (mclk),
        .mst_mosi   (mst_mosi),
        .slv_miso   (slv_miso),
        .sck_i      (sck_i),
        .si_i       (si_i),
        .so_i       (so_i),
        .sck_o      (sck_o),
        .sck_oe     (sck_oe),
        .si_o       (si_o),
        .si_oe      (si_oe),
        .so_o       (so_o),
        .so_oe      (so_oe),
        .cs_o       (cs_o),
        .cs_oe      (cs_oe),
        .mst_miso   (mst_miso),
        .slv_sck    (slv_sck),
        .slv_mosi   (slv_mosi),
        .rel_shared (rel_shared),
        .rel_sn     (rel_sn),
        .rel_cs     (rel_cs)
    );

    assign mst_grant = grant;
    assign slv_sel   = slave_on;

endmodule

// File: rtl/spi_pin_arbiter_chk.sv
`timescale 1ns/1ps
module spi_pin_arbiter_chk
    import spi_arb_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             user_mode,
    input logic             slv_en,
    input logic             mst_en,
    input logic             sn_i,
    input logic             sck_o,
    input logic             sck_oe,
    input logic             si_oe,
    input logic             so_oe,
    input logic             cs_oe,
    input logic             mst_grant,
    input logic             mst_abort,
    input logic [DIV_W-1:0] div_cur,
    input own_state_e       own_st
);

    a_r2_select_blocks_master: assert property (@(posedge clk) disable iff (!rst_n)
        (!sn_i && (!user_mode || slv_en)) |-> (!cs_oe && !sck_oe && !si_oe));

    a_r8_gap_before_slave: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> (!$past(sck_oe) && !$past(cs_oe)));

    a_r8_gap_before_master: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_oe) |-> !$past(so_oe));

    a_r7_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        mst_abort |=> !mst_abort);

    a_r7_abort_after_master: assert property (@(posedge clk) disable iff (!rst_n)
        mst_abort |-> ($past(own_st) == OWN_MASTER));

    a_r5_clock_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_oe |-> !sck_o);

    a_r9_divider_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && $past(user_mode)) |-> $stable(div_cur));

    a_r10_master_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && !mst_en) |-> (!mst_grant && !cs_oe));

endmodule

bind spi_pin_arbiter spi_pin_arbiter_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .user_mode (user_mode),
    .slv_en    (slv_en),
    .mst_en    (mst_en),
    .sn_i      (sn_i),
    .sck_o     (sck_o),
    .sck_oe    (sck_oe),
    .si_oe     (si_oe),
    .so_oe     (so_oe),
    .cs_oe     (cs_oe),
    .mst_grant (mst_grant),
    .mst_abort (mst_abort),
    .div_cur   (div_cur),
    .own_st    (own_st)
);

// File: tb/spi_pin_arbiter_bench.sv
`timescale 1ns/1ps
module spi_pin_arbiter_bench;

    localparam int DW  = 8;
    localparam int DEF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic user_mode = 1'b0, slv_en = 1'b0, mst_en = 1'b0, sn_i = 1'b1;
    logic mst_req = 1'b0, mst_done = 1'b0, mst_mosi = 1'b0, div_load = 1'b0;
    logic [DW-1:0] div_prog = '0;
    logic slv_miso = 1'b0, sck_i = 1'b0, si_i = 1'b0, so_i = 1'b0;
    logic mst_miso, mst_grant, mst_abort, slv_sel, slv_sck, slv_mosi;
    logic sck_o, sck_oe, si_o, si_oe, so_o, so_oe, cs_o, cs_oe;
    logic rel_shared, rel_sn, rel_cs;
    logic [DW-1:0] div_cur;

    int vectors = 0;
    int miscompares = 0;
    bit cyc_bad;
    bit prev_m = 0, prev_s = 0;

    // reference model state: 0 idle, 1 slave, 2 master, 3 abort
    int m_st = 0, m_cnt = 0, m_div = DEF;
    bit m_mclk = 0, m_um = 0;

    always #2 clk = ~clk;

    spi_pin_arbiter #(.DIV_W(DW), .DIV_DEFAULT(DEF)) u_spi_pin_arbiter (
        .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .slv_en(slv_en), .mst_en(mst_en),
        .sn_i(sn_i), .mst_req(mst_req), .mst_done(mst_done), .mst_mosi(mst_mosi),
        .mst_miso(mst_miso), .mst_grant(mst_grant), .mst_abort(mst_abort),
        .div_load(div_load), .div_prog(div_prog), .div_cur(div_cur),
        .slv_miso(slv_miso), .slv_sel(slv_sel), .slv_sck(slv_sck), .slv_mosi(slv_mosi),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .si_i(si_i), .si_o(si_o), .si_oe(si_oe),
        .so_i(so_i), .so_o(so_o), .so_oe(so_oe), .cs_o(cs_o), .cs_oe(cs_oe),
        .rel_shared(rel_shared), .rel_sn(rel_sn), .rel_cs(rel_cs)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fld(input string tag, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            cyc_bad = 1'b1;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    // reference model, advanced on every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_mclk = 0; m_div = DEF; m_um = 0;
        end else begin
            bit sa, ma, run, want;
            sa   = !sn_i && (!user_mode || slv_en);
            ma   = !user_mode || mst_en;
            run  = (m_st == 2) && !sa && ma;
            want = mst_req && ma && !mst_done;
            if (!run) begin m_cnt = 0; m_mclk = 0; end
            else if (m_cnt >= m_div) begin m_cnt = 0; m_mclk = !m_mclk; end
            else m_cnt++;
            if (m_um && !user_mode) m_div = DEF;
            else if (div_load && !user_mode) m_div = int'(div_prog);
            m_um = user_mode;
            case (m_st)
                0: m_st = sa ? 1 : (want ? 2 : 0);
                1: m_st = sa ? 1 : 0;
                2: m_st = sa ? 3 : (want ? 2 : 0);
                default: m_st = sa ? 1 : 0;
            endcase
        end
    end

    // full output comparison every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit sa, ma, g, s;
            sa = !sn_i && (!user_mode || slv_en);
            ma = !user_mode || mst_en;
            g  = (m_st == 2) && !sa && ma;
            s  = (m_st == 1) && (!user_mode || slv_en);
            cyc_bad = 1'b0;
            fld("R4 mst_grant", mst_grant, g);
            fld("R4 cs_oe", cs_oe, g);
            fld("R4 cs_o", cs_o, !g);
            fld("R4 si_oe", si_oe, g);
            fld("R4 si_o", si_o, g && mst_mosi);
            fld("R4 mst_miso", mst_miso, g && so_i);
            fld("R4 sck_oe", sck_oe, g);
            fld("R5 sck_o", sck_o, g && m_mclk);
            fld("R3 slv_sel", slv_sel, s);
            fld("R3 so_oe", so_oe, s);
            fld("R3 so_o", so_o, s && slv_miso);
            fld("R3 slv_sck", slv_sck, s && sck_i);
            fld("R3 slv_mosi", slv_mosi, s && si_i);
            fld("R7 mst_abort", mst_abort, m_st == 3);
            fld("R9 div_cur", div_cur, m_div);
            fld("R10 rel_sn", rel_sn, user_mode && !slv_en);
            fld("R10 rel_cs", rel_cs, user_mode && !mst_en);
            fld("R10 rel_shared", rel_shared, user_mode && !slv_en && !mst_en);
            fld("R8 slave after master", so_oe && prev_m, 1'b0);
            fld("R8 master after slave", (cs_oe || sck_oe) && prev_s, 1'b0);
            prev_m = sck_oe || si_oe || cs_oe;
            prev_s = so_oe;
            vectors++;
            if (cyc_bad) miscompares++;
        end
    end

    // free-running data on the pins and data inputs
    always @(negedge clk) begin
        #1;
        mst_mosi = 1'($urandom);
        slv_miso = 1'($urandom);
        sck_i    = 1'($urandom);
        si_i     = 1'($urandom);
        so_i     = 1'($urandom);
    end

    initial begin
        #(100000 * 4);
        miscompares++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 enables", {sck_oe, si_oe, so_oe, cs_oe}, 4'h0);
        chk("R1 cs_o", cs_o, 1'b1);
        chk("R1 grant/sel/abort", {mst_grant, slv_sel, mst_abort}, 3'b000);
        chk("R1 div_cur", div_cur, DEF);

        // master load at default rate, then divider reprogrammed
        mst_req = 1'b1;
        cyc(3);
        chk("R4 cs driven low", {cs_oe, cs_o}, 2'b10);
        cyc(12);
        div_load = 1'b1; div_prog = 8'd1;
        cyc(1);
        div_load = 1'b0;
        chk("R9 programmed divider", div_cur, 8'd1);
        cyc(16);
        mst_done = 1'b1;
        cyc(1);
        mst_done = 1'b0; mst_req = 1'b0;
        chk("R6 released after done", {cs_oe, sck_oe, si_oe}, 3'b000);
        cyc(2);

        // plain slave access
        sn_i = 1'b0;
        cyc(1);
        chk("R3 slave owns", {slv_sel, so_oe}, 2'b11);
        cyc(10);
        sn_i = 1'b1;
        cyc(2);

        // select falls during a master transfer
        mst_req = 1'b1;
        cyc(6);
        sn_i = 1'b0;
        #0.5;
        chk("R2 same-cycle override", {cs_oe, sck_oe, si_oe, mst_grant}, 4'h0);
        cyc(1);
        chk("R7 abort cycle", {mst_abort, so_oe}, 2'b10);
        mst_req = 1'b0;
        cyc(1);
        chk("R7 slave after abort", {mst_abort, so_oe}, 2'b01);
        cyc(5);
        sn_i = 1'b1;
        cyc(2);

        // simultaneous select and request: slave wins
        sn_i = 1'b0; mst_req = 1'b1;
        cyc(1);
        chk("R3 slave wins tie", {slv_sel, mst_grant}, 2'b10);
        cyc(3);
        sn_i = 1'b1;
        cyc(1);
        chk("R8 idle between owners", {so_oe, cs_oe}, 2'b00);
        cyc(1);
        chk("R4 master after idle", mst_grant, 1'b1);
        cyc(8);
        mst_req = 1'b0;
        cyc(2);

        // user mode, slave port disabled, master port kept
        user_mode = 1'b1; slv_en = 1'b0; mst_en = 1'b1;
        cyc(1);
        chk("R10 release flags", {rel_sn, rel_cs, rel_shared}, 3'b100);
        sn_i = 1'b0; mst_req = 1'b1;
        cyc(2);
        chk("R10 select ignored", {mst_grant, slv_sel}, 2'b10);
        div_load = 1'b1; div_prog = 8'd5;
        cyc(1);
        div_load = 1'b0;
        chk("R9 load ignored in user mode", div_cur, 8'd1);
        cyc(6);
        mst_en = 1'b0;
        #0.5;
        chk("R10 master blocked at once", {mst_grant, cs_oe}, 2'b00);
        cyc(1);
        chk("R10 all released", {rel_shared, rel_cs, sck_oe}, 3'b110);
        mst_req = 1'b0; sn_i = 1'b1;
        cyc(2);

        // user mode with slave kept
        slv_en = 1'b1;
        sn_i = 1'b0;
        cyc(1);
        chk("R3 slave in user mode", so_oe, 1'b1);
        cyc(4);
        sn_i = 1'b1;
        cyc(2);

        // back to configuring: divider default again, run at default
        user_mode = 1'b0;
        cyc(1);
        chk("R9 default restored", div_cur, DEF);
        mst_req = 1'b1;
        cyc(20);
        mst_req = 1'b0;
        cyc(3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule